// File: doc/BRIEF.md
# Pipelined Byte-Lane SRAM with Write Pass-Through

This block is a single-port synchronous memory for the inside of a larger chip. Each word is made of byte lanes. A lane holds eight data bits and one parity bit, and the block stores the parity bit as given without checking it. Every input is captured on the clock edge: the address, the write data, three chip-select inputs and the write controls. A read returns its word through an output register. A write can cover the whole word or any set of lanes. A write is first held in a commit register and reaches the array one cycle later.

A read issued in the cycle right after a write sees that write. The newer lanes are forwarded from the commit register and the other lanes come from the array. An asynchronous output-enable input gates the read bus and its drive flag. The block has no burst counter: the logic above presents one address every cycle.

Top module: `bytelane_sram`

## Requirements
- R1: A word is LANES lanes of 9 bits. Lane l occupies bits [9l+8:9l], and its bit 9l+8 is the parity bit. The parity bit is written and read with its own lane only, like the data bits of that lane.
- R2: While `gw_n_i` is low in a selected cycle, every lane is written whatever `bwe_n_i` and `bw_n_i` hold.
- R3: While `gw_n_i` is high and `bwe_n_i` is low, a selected cycle writes exactly the lanes l with `bw_n_i[l]`=0. The other lanes keep their contents.
- R4: A selected cycle that writes no lane is a read. This covers `gw_n_i` and `bwe_n_i` both high (then `bw_n_i` has no effect), and `bwe_n_i` low with all `bw_n_i` bits high. Such a cycle changes no stored data.
- R5: A cycle is selected only when `ce1_n_i`=0, `ce2_i`=1 and `ce3_n_i`=0. Any other cycle writes nothing, and two edges later `dq_oe_o` is 0.
- R6: The word for a read presented before edge N appears on `rdata_o` after edge N+1 and stays there until edge N+2. Reads can be issued back to back, one per cycle.
- R7: A read of the address written in the cycle just before returns the new data in the written lanes and the earlier contents in the unwritten lanes.
- R8: `oe_n_i` acts without a clock. While it is high, `dq_oe_o` is 0 and `rdata_o` is all zeros. While it is low, a pending read result is driven.
- R9: After a write cycle, `dq_oe_o` stays 0 in the cycle where a read result would otherwise appear.
- R10: While `rst_n` is low at a clock edge, the output register is cleared, so `dq_oe_o` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ce1_n_i | input | 1 | Chip select, active low |
| ce2_i | input | 1 | Chip select, active high |
| ce3_n_i | input | 1 | Chip select, active low |
| addr_i | input | ADDR_W | Word address |
| gw_n_i | input | 1 | Whole-word write, active low |
| bwe_n_i | input | 1 | Lane-write enable, active low |
| bw_n_i | input | LANES | Per-lane write selects, active low |
| wdata_i | input | 9*LANES | Write data with parity bits |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 9*LANES | Read data, zero when not driven |
| dq_oe_o | output | 1 | Read data drive flag |

## Verification
The bench builds the block with four lanes and a 32-word array, which is five address bits. It starts by writing every word with a whole-word write. With only 32 words, random traffic hits the same address often: write-then-read pairs on one address, writes that overlap in their lanes, and reads just behind a partial write all occur at a useful rate. The lane-select patterns, the seven deselect combinations and a mid-cycle change of `oe_n_i` are also driven in directed sequences.

// File: rtl/bytelane_sram_pkg.sv
// Package: constants and the access type shared by the byte-lane SRAM modules.
// Assumes: a lane is always eight data bits plus one parity bit.
package bytelane_sram_pkg;

    localparam int LANE_DATA_W = 8;
    localparam int LANE_W      = LANE_DATA_W + 1;

    // Class of access captured in the input register
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } sram_op_e;

endpackage

// File: rtl/bls_in_stage.sv
// Module: bls_in_stage
// Decodes the chip selects and the write controls, then captures the access
// in the input register. It assumes all inputs are synchronous to clk.
// A selected access with an empty lane mask is classed as a read.
module bls_in_stage
    import bytelane_sram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ce1_n_i,
    input  logic                      ce2_i,
    input  logic                      ce3_n_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic                      gw_n_i,
    input  logic                      bwe_n_i,
    input  logic [LANES-1:0]          bw_n_i,
    input  logic [LANES*LANE_W-1:0]   wdata_i,
    output sram_op_e                  s1_op_o,
    output logic [ADDR_W-1:0]         s1_addr_o,
    output logic [LANES-1:0]          s1_mask_o,
    output logic [LANES*LANE_W-1:0]   s1_wdata_o
);

    localparam int WORD_W = LANES * LANE_W;

    logic             sel_c;
    logic [LANES-1:0] mask_c;
    sram_op_e         op_c;

    // Chip is selected only for the single enabling combination
    assign sel_c = !ce1_n_i && ce2_i && !ce3_n_i;

    // Per-lane write enable: the whole-word write overrides the lane selects
    for (genvar l = 0; l < LANES; l++) begin : g_lane_we
        assign mask_c[l] = !gw_n_i || (!bwe_n_i && !bw_n_i[l]);
    end

    // Classify the access from the select and the lane mask
    always_comb begin
        if (!sel_c)          op_c = OP_IDLE;
        else if (|mask_c)    op_c = OP_WRITE;
        else                 op_c = OP_READ;
    end

    // Input register for the access type, the mask, the address and the data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_op_o    <= OP_IDLE;
            s1_mask_o  <= '0;
            s1_addr_o  <= '0;
            s1_wdata_o <= '0;
        end else begin
            s1_op_o    <= op_c;
            s1_mask_o  <= (op_c == OP_WRITE) ? mask_c : '0;
            s1_addr_o  <= addr_i;
            s1_wdata_o <= wdata_i[WORD_W-1:0];
        end
    end

endmodule

// File: rtl/bls_array.sv
// Module: bls_array
// Storage array and commit register. A write from the input register first
// goes into the commit register, and the masked lanes are written into the
// array on the next edge. The array is read without a clock. It assumes the
// caller merges the commit register into reads of the same address.
// The storage itself is not reset.
module bls_array
    import bytelane_sram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [ADDR_W-1:0]         wr_addr_i,
    input  logic [LANES-1:0]          wr_mask_i,
    input  logic [LANES*LANE_W-1:0]   wr_data_i,
    input  logic [ADDR_W-1:0]         rd_addr_i,
    output logic [LANES*LANE_W-1:0]   rd_word_o,
    output logic                      cm_valid_o,
    output logic [ADDR_W-1:0]         cm_addr_o,
    output logic [LANES-1:0]          cm_mask_o,
    output logic [LANES*LANE_W-1:0]   cm_data_o
);

    localparam int WORD_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];

    // Commit register: holds a captured write for one cycle before the array
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cm_valid_o <= 1'b0;
            cm_addr_o  <= '0;
            cm_mask_o  <= '0;
            cm_data_o  <= '0;
        end else begin
            cm_valid_o <= wr_en_i;
            cm_addr_o  <= wr_addr_i;
            cm_mask_o  <= wr_en_i ? wr_mask_i : '0;
            cm_data_o  <= wr_data_i;
        end
    end

    // Array write: only the lanes selected in the commit mask are updated
    always_ff @(posedge clk) begin
        if (cm_valid_o) begin
            for (int l = 0; l < LANES; l++) begin
                if (cm_mask_o[l]) begin
                    mem_q[cm_addr_o][l*LANE_W +: LANE_W] <= cm_data_o[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Array read port, combinational
    assign rd_word_o = mem_q[rd_addr_i];

endmodule

// File: rtl/bls_fwd_merge.sv
// Module: bls_fwd_merge
// Write pass-through. The full read address is compared with the commit
// register. On a match, each lane the pending write covers is taken from the
// commit register and every other lane is taken from the array word.
// Purely combinational.
module bls_fwd_merge
    import bytelane_sram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]         rd_addr_i,
    input  logic [LANES*LANE_W-1:0]   arr_word_i,
    input  logic                      cm_valid_i,
    input  logic [ADDR_W-1:0]         cm_addr_i,
    input  logic [LANES-1:0]          cm_mask_i,
    input  logic [LANES*LANE_W-1:0]   cm_data_i,
    output logic [LANES*LANE_W-1:0]   merged_o
);

    logic addr_hit;

    // A single full-width compare is shared by all lanes
    assign addr_hit = cm_valid_i && (cm_addr_i == rd_addr_i);

    // Lane-wise choice between the pending write and the array contents
    for (genvar l = 0; l < LANES; l++) begin : g_lane_mux
        assign merged_o[l*LANE_W +: LANE_W] = (addr_hit && cm_mask_i[l])
                                            ? cm_data_i[l*LANE_W +: LANE_W]
                                            : arr_word_i[l*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/bls_out_stage.sv
// Module: bls_out_stage
// Output register and drive gating. The enable delay register follows the
// read pipeline: it is set only after a selected read. The asynchronous
// output enable zeroes the bus and the drive flag without a clock edge.
module bls_out_stage
    import bytelane_sram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en_i,
    input  logic [LANES*LANE_W-1:0]   rd_word_i,
    input  logic                      oe_n_i,
    output logic [LANES*LANE_W-1:0]   rdata_o,
    output logic                      dq_oe_o
);

    logic                      rd_vld_q;
    logic [LANES*LANE_W-1:0]   rd_q;

    // Output register; the data is held and the valid flag tracks the read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld_q <= 1'b0;
            rd_q     <= '0;
        end else begin
            rd_vld_q <= rd_en_i;
            if (rd_en_i) begin
                rd_q <= rd_word_i;
            end
        end
    end

    // Combinational drive gating by the output enable
    always_comb begin
        dq_oe_o = rd_vld_q && !oe_n_i;
        rdata_o = dq_oe_o ? rd_q : '0;
    end

endmodule

// File: rtl/bytelane_sram.sv
// Module: bytelane_sram (top)
// Pipelined single-port SRAM with byte-lane writes, a whole-word write
// override, three chip selects and write-to-read pass-through.
// Pipeline: input register -> (array read + forward merge) -> output register.
// Writes go input register -> commit register -> array.
// It assumes the logic above presents one address per cycle.
module bytelane_sram
    import bytelane_sram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ce1_n_i,
    input  logic                      ce2_i,
    input  logic                      ce3_n_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic                      gw_n_i,
    input  logic                      bwe_n_i,
    input  logic [LANES-1:0]          bw_n_i,
    input  logic [LANES*LANE_W-1:0]   wdata_i,
    input  logic                      oe_n_i,
    output logic [LANES*LANE_W-1:0]   rdata_o,
    output logic                      dq_oe_o
);

    localparam int WORD_W = LANES * LANE_W;

    sram_op_e          s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_mask;
    logic [WORD_W-1:0] s1_wdata;
    logic [WORD_W-1:0] arr_word;
    logic              cm_valid;
    logic [ADDR_W-1:0] cm_addr;
    logic [LANES-1:0]  cm_mask;
    logic [WORD_W-1:0] cm_data;
    logic [WORD_W-1:0] merged;
    logic              s1_is_wr;
    logic              s1_is_rd;

    // Stage-1 access type decode
    assign s1_is_wr = (s1_op == OP_WRITE);
    assign s1_is_rd = (s1_op == OP_READ);

    bls_in_stage #(.LANES(LANES), .ADDR_W(ADDR_W)) u_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce1_n_i   (ce1_n_i),
        .ce2_i     (ce2_i),
        .ce3_n_i   (ce3_n_i),
        .addr_i    (addr_i),
        .gw_n_i    (gw_n_i),
        .bwe_n_i   (bwe_n_i),
        .bw_n_i    (bw_n_i),
        .wdata_i   (wdata_i),
        .s1_op_o   (s1_op),
        .s1_addr_o (s1_addr),
        .s1_mask_o (s1_mask),
        .s1_wdata_o(s1_wdata)
    );

    bls_array #(.LANES(LANES), .ADDR_W(ADDR_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (s1_is_wr),
        .wr_addr_i (s1_addr),
        .wr_mask_i (s1_mask),
        .wr_data_i (s1_wdata),
        .rd_addr_i (s1_addr),
        .rd_word_o (arr_word),
        .cm_valid_o(cm_valid),
        .cm_addr_o (cm_addr),
        .cm_mask_o (cm_mask),
        .cm_data_o (cm_data)
    );

    bls_fwd_merge #(.LANES(LANES), .ADDR_W(ADDR_W)) u_fwd (
        .rd_addr_i (s1_addr),
        .arr_word_i(arr_word),
        .cm_valid_i(cm_valid),
        .cm_addr_i (cm_addr),
        .cm_mask_i (cm_mask),
        .cm_data_i (cm_data),
        .merged_o  (merged)
    );

    bls_out_stage #(.LANES(LANES)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en_i  (s1_is_rd),
        .rd_word_i(merged),
        .oe_n_i   (oe_n_i),
        .rdata_o  (rdata_o),
        .dq_oe_o  (dq_oe_o)
    );

endmodule

// File: rtl/bytelane_sram_chk.sv
// Module: bytelane_sram_chk
// Checker bound to bytelane_sram. Its properties relate the port inputs to
// the output drive flag and the bus two edges later.
module bytelane_sram_chk
    import bytelane_sram_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ce1_n_i,
    input logic                      ce2_i,
    input logic                      ce3_n_i,
    input logic                      gw_n_i,
    input logic                      bwe_n_i,
    input logic [LANES-1:0]          bw_n_i,
    input logic                      oe_n_i,
    input logic [LANES*LANE_W-1:0]   rdata_o,
    input logic                      dq_oe_o
);

    logic sel;
    logic wr;

    // Port-level view of the access class
    assign sel = !ce1_n_i && ce2_i && !ce3_n_i;
    assign wr  = !gw_n_i || (!bwe_n_i && (bw_n_i != {LANES{1'b1}}));

    // R10
    rst_clears_out_chk: assert property (@(posedge clk) !rst_n |=> !dq_oe_o);

    // R8
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> (!dq_oe_o && (rdata_o == '0)));

    // R5
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> ##2 !dq_oe_o);

    // R9
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr) |-> ##2 !dq_oe_o);

    // R6
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr) |-> ##2 (dq_oe_o == !oe_n_i));

endmodule

bind bytelane_sram bytelane_sram_chk #(.LANES(LANES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce1_n_i(ce1_n_i),
    .ce2_i  (ce2_i),
    .ce3_n_i(ce3_n_i),
    .gw_n_i (gw_n_i),
    .bwe_n_i(bwe_n_i),
    .bw_n_i (bw_n_i),
    .oe_n_i (oe_n_i),
    .rdata_o(rdata_o),
    .dq_oe_o(dq_oe_o)
);

// File: tb/bytelane_sram_test.sv
`timescale 1ns/1ps
module bytelane_sram_test;

    localparam int LANES  = 4;
    localparam int ADDR_W = 5;
    localparam int W      = LANES * 9;
    localparam int DEPTH  = 1 << ADDR_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ce1_n_i = 1'b1, ce2_i = 1'b0, ce3_n_i = 1'b1;
    logic [ADDR_W-1:0] addr_i = '0;
    logic             gw_n_i = 1'b1, bwe_n_i = 1'b1;
    logic [LANES-1:0] bw_n_i = '1;
    logic [W-1:0]     wdata_i = '0;
    logic             oe_n_i = 1'b0;
    logic [W-1:0]     rdata_o;
    logic             dq_oe_o;

    int n_vec = 0;
    int n_bad = 0;

    logic [W-1:0] model [DEPTH];
    logic         q_v [2];
    logic [W-1:0] q_d [2];
    string        q_t [2];
    logic         prev_wr = 1'b0;
    logic [ADDR_W-1:0] prev_wa = '0;

    bytelane_sram #(.LANES(LANES), .ADDR_W(ADDR_W)) uut (.*);

    always #2.5 clk = ~clk;

    // Watchdog: a hung run is reported as a failure
    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog (R6) actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    function automatic logic [W-1:0] rnd_word();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[W-1:0];
    endfunction

    // Write mask from the requirements (R2, R3, R4)
    function automatic logic [LANES-1:0] exp_mask(logic gwn, logic bwen, logic [LANES-1:0] bwn);
        if (!gwn) return '1;
        if (!bwen) return ~bwn;
        return '0;
    endfunction

    // Lane merge per R1: lane l is bits [9l+8:9l]
    function automatic logic [W-1:0] merge(logic [W-1:0] old, logic [W-1:0] nw, logic [LANES-1:0] m);
        logic [W-1:0] r = old;
        for (int l = 0; l < LANES; l++) if (m[l]) r[l*9 +: 9] = nw[l*9 +: 9];
        return r;
    endfunction

    task automatic cmp(string tag, logic exp_en, logic [W-1:0] exp_d);
        n_vec++;
        if (dq_oe_o !== exp_en || rdata_o !== exp_d) begin
            n_bad++;
            $display("FAIL %s: actual en=%0b data=%h expected en=%0b data=%h",
                     tag, dq_oe_o, rdata_o, exp_en, exp_d);
        end
    endtask

    // One cycle: check the op of two steps ago, then drive a new op
    task automatic step(logic c1n, logic c2, logic c3n, logic gwn, logic bwen,
                        logic [LANES-1:0] bwn, logic [ADDR_W-1:0] a,
                        logic [W-1:0] d, logic oen, string tag);
        logic sel;
        logic [LANES-1:0] m;
        string t;
        @(negedge clk);
        cmp(q_t[1], q_v[1] && !oe_n_i, (q_v[1] && !oe_n_i) ? q_d[1] : '0);
        q_v[1] = q_v[0]; q_d[1] = q_d[0]; q_t[1] = q_t[0];
        ce1_n_i = c1n; ce2_i = c2; ce3_n_i = c3n; gw_n_i = gwn; bwe_n_i = bwen;
        bw_n_i = bwn; addr_i = a; wdata_i = d; oe_n_i = oen;
        sel = !c1n && c2 && !c3n;
        m = exp_mask(gwn, bwen, bwn);
        if (!sel) begin
            q_v[0] = 1'b0; q_d[0] = '0; t = "R5";
            prev_wr = 1'b0;
        end else if (m != '0) begin
            model[a] = merge(model[a], d, m);
            q_v[0] = 1'b0; q_d[0] = '0; t = "R9";
            prev_wr = 1'b1; prev_wa = a;
        end else begin
            q_v[0] = 1'b1; q_d[0] = model[a];
            t = (prev_wr && prev_wa == a) ? "R7" : "R6";
            prev_wr = 1'b0;
        end
        q_t[0] = (tag == "") ? t : tag;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, string tag);
        step(0, 1, 0, 1, 1, '1, a, rnd_word(), 0, tag);
    endtask
    task automatic wr(logic [ADDR_W-1:0] a, logic [LANES-1:0] bwn, logic [W-1:0] d);
        step(0, 1, 0, 1, 0, bwn, a, d, 0, "");
    endtask
    task automatic wr_all(logic [ADDR_W-1:0] a, logic [W-1:0] d);
        step(0, 1, 0, 0, 1, '1, a, d, 0, "");
    endtask
    task automatic idle();
        step(1, 0, 1, 1, 1, '1, '0, '0, 0, "");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ce1_n_i = 1'b1; gw_n_i = 1'b1; bwe_n_i = 1'b1; oe_n_i = 1'b0;
        q_v[0] = 0; q_v[1] = 0; prev_wr = 0;
        @(negedge clk);
        cmp("R10", 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [W-1:0] d1, d2, par;
        logic [ADDR_W-1:0] a;
        void'($urandom(32'd20240611));
        q_v[0] = 0; q_v[1] = 0; q_d[0] = '0; q_d[1] = '0; q_t[0] = "R10"; q_t[1] = "R10";
        repeat (3) @(negedge clk);
        cmp("R10", 1'b0, '0);
        rst_n = 1'b1;

        // Fill every word with a whole-word write
        for (int i = 0; i < DEPTH; i++) wr_all(i[ADDR_W-1:0], rnd_word());
        idle(); idle();

        // R2: whole-word write overrides lane controls
        d1 = rnd_word();
        step(0, 1, 0, 0, 0, '1, 5'd3, d1, 0, "");
        rd(5'd3, "R2");
        idle();
        rd(5'd3, "R2");

        // R3: lanes 0 and 2 only
        d2 = rnd_word();
        wr(5'd4, 4'b1010, d2);
        idle(); idle();
        rd(5'd4, "R3");

        // R4: both write controls high, lane selects low -> read, no change
        step(0, 1, 0, 1, 1, '0, 5'd4, rnd_word(), 0, "R4");
        rd(5'd4, "R4");
        step(0, 1, 0, 1, 0, '1, 5'd4, rnd_word(), 0, "R4");
        rd(5'd4, "R4");

        // R1: parity bits only, lane 3
        par = '0;
        for (int l = 0; l < LANES; l++) par[l*9 + 8] = 1'b1;
        wr(5'd6, 4'b0111, par);
        idle();
        rd(5'd6, "R1");
        wr_all(5'd7, '0);
        wr(5'd7, 4'b1110, par);
        rd(5'd7, "R1");

        // R7: pass-through on a partial write, and write-write-read
        wr_all(5'd8, rnd_word());
        idle(); idle();
        wr(5'd8, 4'b1101, rnd_word());
        rd(5'd8, "R7");
        wr(5'd9, 4'b0000, rnd_word());
        wr(5'd9, 4'b0011, rnd_word());
        rd(5'd9, "R7");

        // R5: every deselect combination with a whole-word write attempt
        for (int c = 0; c < 8; c++) begin
            if (c != 3'b010) step(c[2], c[1], c[0], 0, 0, '0, 5'd10, rnd_word(), 0, "R5");
        end
        rd(5'd10, "R5");

        // R6: back-to-back reads
        for (int i = 0; i < 6; i++) rd(i[ADDR_W-1:0], "R6");

        // R8: asynchronous output enable mid-cycle
        rd(5'd11, "R6");
        d1 = model[11];
        idle();
        idle();
        #0.5 oe_n_i = 1'b1;
        #0.5 cmp("R8", 1'b0, '0);
        oe_n_i = 1'b0;
        #0.5 cmp("R8", 1'b1, d1);

        // R10: reset clears a pending read result
        rd(5'd12, "R6");
        idle();
        do_reset();

        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic oen;
            r = $urandom_range(0, 99);
            a = ($urandom_range(0, 3) == 0) ? ADDR_W'($urandom_range(0, DEPTH-1))
                                             : ADDR_W'($urandom_range(0, 5));
            oen = ($urandom_range(0, 9) == 0);
            if (r < 35)      step(0, 1, 0, 1, 1, LANES'($urandom()), a, rnd_word(), oen, "");
            else if (r < 50) step(0, 1, 0, 0, 1'($urandom()), LANES'($urandom()), a, rnd_word(), oen, "");
            else if (r < 80) step(0, 1, 0, 1, 0, LANES'($urandom()), a, rnd_word(), oen, "");
            else begin
                int c;
                c = $urandom_range(0, 6);
                if (c >= 2) c++;
                step(c[2], c[1], c[0], 1'($urandom()), 1'($urandom()), LANES'($urandom()),
                     a, rnd_word(), oen, "");
            end
        end
        idle(); idle();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule